// File: doc/BRIEF.md
# Simultaneous ADC Conversion Trigger

This controller starts a conversion on a group of sampling converters at one shared instant and then collects their results. A single start request produces one conversion-start strobe, several system clock cycles wide, that is wired to every converter's start input. The controller never pulses channels one at a time, so every channel samples on the same edge.

After the strobe the controller waits for the converters' shared end-of-conversion line. This line can work as a busy signal or as an interrupt, and its active level is chosen by a configuration input. The line passes through a two-flop synchronizer first. When the synchronized level matches the selected active level, the controller runs a read phase. The read phase issues one read strobe per converter with an incrementing channel index, so that surrounding logic can load each result word into its own holding register. In interrupt mode the converters keep the line active until they are read, so the first read strobe is the access that clears it. A done pulse ends the sequence. If the line never reaches its active level, a wait counter gives up, raises a sticky error flag and returns the controller to idle.

Top module: `adc_sync_trigger`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `conv_start`, `rd_strobe`, `done` and `timeout_err` are all 0.
- R2: A `start_req` sampled high while idle makes `conv_start` high on the next cycle, for exactly PULSE_CYCLES consecutive cycles (default 2). `conv_start` is never high in the same cycle as `rd_strobe` or `done`.
- R3: `eoc_line` is sampled through two flops. While waiting, the first read strobe appears in the third cycle after the cycle in which the line reaches its active level.
- R4: The active level of `eoc_line` is high when `eoc_active_high` is 1 and low when it is 0. The opposite level never ends the wait.
- R5: `eoc_line` is examined only during the wait. An active level held at any other time, such as an interrupt left asserted after the read phase, starts no read strobe and no new conversion.
- R6: The read phase gives exactly N_CONV consecutive cycles of `rd_strobe`, with `rd_chan` running 0, 1, …, N_CONV-1.
- R7: `done` is high for exactly one cycle, in the cycle right after the last read strobe. The controller is idle in the cycle after that.
- R8: A `start_req` that arrives while the controller is not idle is ignored. It produces no additional `conv_start` cycle at that time or later.
- R9: If the wait lasts TIMEOUT_CYCLES cycles without an active level, `timeout_err` goes to 1 and the controller returns to idle without any read strobe. `timeout_err` stays 1 until the next accepted start request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to start one simultaneous conversion |
| eoc_line | input | 1 | Shared busy/interrupt line from the converters (asynchronous) |
| eoc_active_high | input | 1 | Selects the active level of `eoc_line`: 1 = high, 0 = low |
| conv_start | output | 1 | Shared conversion-start strobe to all converters |
| rd_strobe | output | 1 | One-cycle read strobe for the channel on `rd_chan` |
| rd_chan | output | CHW | Index of the converter being read |
| done | output | 1 | One-cycle pulse when all channels have been read |
| timeout_err | output | 1 | Sticky flag: end of conversion did not arrive in time |

## Verification
A wrong internal phase shows up at the ports in the very next cycle. A stretched or clipped start strobe, a read strobe with no active level before it, or a done pulse that does not follow channel N_CONV-1 each changes an output on the cycle the phase goes wrong. An off-by-one in the synchronizer depth or the wait limit shifts the first read strobe, or the rise of the error flag, by one cycle relative to the line change. A behavioural model tracks every output cycle by cycle, so such a shift is flagged at the first cycle where it occurs. A polarity fault appears as a read phase that starts on the inactive level, or as a wait that runs to timeout.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_READ  = 3'd3,
    ST_DONE  = 3'd4
  } trig_state_e;

  // Bits needed to count 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // True when the synchronized line sits at the configured active level.
  function automatic logic level_active(input logic line, input logic active_high);
    return line == active_high;
  endfunction

endpackage

// File: rtl/adc_trig_counter.sv
module adc_trig_counter #(
  parameter int unsigned LIMIT = 2,
  parameter int unsigned W     = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count,
  output logic         at_last
);

  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign at_last = (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clr)              count <= '0;
    else if (en && !at_last)   count <= count + 1'b1;
  end

endmodule

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  input  logic active_high,
  output logic eoc_hit
);
  import adc_trig_pkg::*;

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= line_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], line_async};
      end
    end
  endgenerate

  assign eoc_hit = level_active(sync_q[STAGES-1], active_high);

endmodule

// File: rtl/adc_sync_trigger.sv
module adc_sync_trigger #(
  parameter int unsigned N_CONV         = 4,
  parameter int unsigned PULSE_CYCLES   = 2,
  parameter int unsigned TIMEOUT_CYCLES = 4096,
  parameter int unsigned CHW            = adc_trig_pkg::cnt_width(N_CONV)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic           eoc_line,
  input  logic           eoc_active_high,
  output logic           conv_start,
  output logic           rd_strobe,
  output logic [CHW-1:0] rd_chan,
  output logic           done,
  output logic           timeout_err
);
  import adc_trig_pkg::*;

  localparam int unsigned PW_W = cnt_width(PULSE_CYCLES);
  localparam int unsigned TO_W = cnt_width(TIMEOUT_CYCLES);

  trig_state_e st_q, st_d;

  // Named internal events
  logic            eoc_hit;
  logic            start_accept;
  logic            pulse_last;
  logic            wait_last;
  logic            read_last;
  logic            timeout_evt;
  logic [PW_W-1:0] pulse_cnt;
  logic [TO_W-1:0] wait_cnt;
  logic            err_q;

  adc_eoc_sync #(.STAGES(2)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_async  (eoc_line),
    .active_high (eoc_active_high),
    .eoc_hit     (eoc_hit)
  );

  adc_trig_counter #(.LIMIT(PULSE_CYCLES), .W(PW_W)) u_pulse_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q != ST_PULSE),
    .en      (st_q == ST_PULSE),
    .count   (pulse_cnt),
    .at_last (pulse_last)
  );

  adc_trig_counter #(.LIMIT(TIMEOUT_CYCLES), .W(TO_W)) u_wait_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q != ST_WAIT),
    .en      (st_q == ST_WAIT),
    .count   (wait_cnt),
    .at_last (wait_last)
  );

  adc_trig_counter #(.LIMIT(N_CONV), .W(CHW)) u_chan_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q != ST_READ),
    .en      (st_q == ST_READ),
    .count   (rd_chan),
    .at_last (read_last)
  );

  assign start_accept = (st_q == ST_IDLE) && start_req;
  assign timeout_evt  = (st_q == ST_WAIT) && !eoc_hit && wait_last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_req)  st_d = ST_PULSE;
      ST_PULSE: if (pulse_last) st_d = ST_WAIT;
      ST_WAIT: begin
        if (eoc_hit)        st_d = ST_READ;
        else if (wait_last) st_d = ST_IDLE;
      end
      ST_READ:  if (read_last)  st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_accept)     err_q <= 1'b0;
      else if (timeout_evt) err_q <= 1'b1;
    end
  end

  assign conv_start  = (st_q == ST_PULSE);
  assign rd_strobe   = (st_q == ST_READ);
  assign done        = (st_q == ST_DONE);
  assign timeout_err = err_q;

endmodule

// File: rtl/adc_sync_trigger_chk.sv
module adc_sync_trigger_chk
  import adc_trig_pkg::*;
#(
  parameter int unsigned N_CONV = 4,
  parameter int unsigned CHW    = 2,
  parameter int unsigned PW_W   = 1,
  parameter int unsigned TO_W   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_req,
  input logic            conv_start,
  input logic            rd_strobe,
  input logic [CHW-1:0]  rd_chan,
  input logic            done,
  input logic            timeout_err,
  input logic            eoc_hit,
  input trig_state_e     st_q,
  input logic [PW_W-1:0] pulse_cnt,
  input logic [TO_W-1:0] wait_cnt
);

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, rd_strobe, done})); // R2

  AST_PULSE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && pulse_cnt != '0) |-> $past(conv_start)); // R2

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> ($past(start_req) && $past(st_q) == ST_IDLE)); // R8

  AST_READ_AFTER_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_strobe) |-> ($past(eoc_hit) && rd_chan == '0)); // R3

  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && $past(rd_strobe)) |-> (rd_chan == CHW'($past(rd_chan) + 1'b1))); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rd_strobe) && $past(rd_chan) == CHW'(N_CONV - 1))); // R7

  AST_ERR_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> ($past(st_q) == ST_WAIT && !$past(eoc_hit) && !rd_strobe)); // R9

  AST_WAIT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && $past(st_q) == ST_PULSE) |-> (wait_cnt == '0)); // R9

endmodule

bind adc_sync_trigger adc_sync_trigger_chk #(
  .N_CONV (N_CONV),
  .CHW    (CHW),
  .PW_W   (PW_W),
  .TO_W   (TO_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_req   (start_req),
  .conv_start  (conv_start),
  .rd_strobe   (rd_strobe),
  .rd_chan     (rd_chan),
  .done        (done),
  .timeout_err (timeout_err),
  .eoc_hit     (eoc_hit),
  .st_q        (st_q),
  .pulse_cnt   (pulse_cnt),
  .wait_cnt    (wait_cnt)
);

// File: tb/adc_sync_trigger_tb_top.sv
module adc_sync_trigger_tb_top;

  localparam int N   = 4;
  localparam int PW  = 2;
  localparam int TO  = 20;
  localparam int DLY = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_req;
  logic       eoc_pol;
  logic       man_en, man_val;
  logic       adc_en;
  logic       adc_act;
  logic       eoc_line;
  logic       conv_start, rd_strobe, done, timeout_err;
  logic [1:0] rd_chan;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign eoc_line = man_en ? man_val : (adc_act ? eoc_pol : !eoc_pol);

  adc_sync_trigger #(
    .N_CONV(N), .PULSE_CYCLES(PW), .TIMEOUT_CYCLES(TO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .eoc_line(eoc_line),
    .eoc_active_high(eoc_pol), .conv_start(conv_start), .rd_strobe(rd_strobe),
    .rd_chan(rd_chan), .done(done), .timeout_err(timeout_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural converter: line goes active DLY cycles after the start strobe ends,
  // and the first read strobe clears it.
  int adc_cd = 0;
  int eoc_set_cyc = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      adc_act <= 1'b0;
      adc_cd  = 0;
    end else if (adc_en) begin
      if (rd_strobe) adc_act <= 1'b0;
      else if (conv_start) adc_cd = DLY;
      else if (adc_cd > 0) begin
        adc_cd--;
        if (adc_cd == 0) begin
          adc_act <= 1'b1;
          eoc_set_cyc = cyc;
        end
      end
    end
  end

  // Reference model: phase 0 idle, 1 strobe, 2 wait, 3 read, 4 done
  int m_phase = 0, m_n = 0;
  bit m_err = 0, m_s1 = 0, m_s2 = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_n = 0; m_err = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      bit act;
      act = (m_s2 == eoc_pol);
      case (m_phase)
        0: if (start_req) begin m_phase = 1; m_n = 0; m_err = 0; end
        1: if (m_n == PW - 1) begin m_phase = 2; m_n = 0; end else m_n++;
        2: if (act) begin m_phase = 3; m_n = 0; end
           else if (m_n == TO - 1) begin m_phase = 0; m_n = 0; m_err = 1; end
           else m_n++;
        3: if (m_n == N - 1) begin m_phase = 4; m_n = 0; end else m_n++;
        default: begin m_phase = 0; m_n = 0; end
      endcase
      m_s2 = m_s1;
      m_s1 = eoc_line;
    end
  end

  // Per-cycle comparison and event tallies
  int n_cs = 0, n_rd = 0, n_done = 0, rd_rise_cyc = 0;
  bit prev_rd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "conv_start", conv_start, m_phase == 1);
      chk("R6", "rd_strobe", rd_strobe, m_phase == 3);
      if (m_phase == 3) chk("R6", "rd_chan", rd_chan, m_n);
      chk("R7", "done", done, m_phase == 4);
      chk("R9", "timeout_err", timeout_err, m_err);
      if (conv_start) n_cs++;
      if (rd_strobe) n_rd++;
      if (done) n_done++;
      if (rd_strobe && !prev_rd) rd_rise_cyc = cyc;
      prev_rd = rd_strobe;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int base = n_done;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (n_done != base) return;
    end
    chk(req, "done reached", 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; start_req = 1'b0; eoc_pol = 1'b1;
    man_en = 1'b1; man_val = 1'b0; adc_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {conv_start, rd_strobe, done, timeout_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset outputs", {conv_start, rd_strobe, done, timeout_err}, 0);

    // Active-high line, converter model drives it
    begin
      int b_cs, b_rd, b_dn;
      man_en = 1'b0;
      repeat (4) @(negedge clk);
      b_cs = n_cs; b_rd = n_rd; b_dn = n_done;
      pulse_start();
      wait_done("R7");
      chk("R2", "strobe cycles high-pol", n_cs - b_cs, PW);
      chk("R6", "read strobes high-pol", n_rd - b_rd, N);
      chk("R7", "done pulses", n_done - b_dn, 1);
      chk("R3", "sync latency", rd_rise_cyc - eoc_set_cyc, 3);
      @(negedge clk);
      chk("R7", "idle after done", {conv_start, rd_strobe, done}, 0);
    end

    // Active-low line
    begin
      int b_cs, b_rd;
      eoc_pol = 1'b0;
      repeat (4) @(negedge clk);
      b_cs = n_cs; b_rd = n_rd;
      pulse_start();
      wait_done("R4");
      chk("R4", "strobe cycles low-pol", n_cs - b_cs, PW);
      chk("R4", "read strobes low-pol", n_rd - b_rd, N);
      chk("R4", "sync latency low-pol", rd_rise_cyc - eoc_set_cyc, 3);
      eoc_pol = 1'b1;
      repeat (4) @(negedge clk);
    end

    // Start requests while busy are ignored
    begin
      int b_cs;
      b_cs = n_cs;
      @(negedge clk) start_req = 1'b1;
      repeat (10) @(negedge clk);
      start_req = 1'b0;
      wait_done("R8");
      repeat (12) @(negedge clk);
      chk("R8", "strobe cycles with held request", n_cs - b_cs, PW);
    end

    // Interrupt left active after the read phase has no effect
    begin
      int b_cs, b_rd;
      man_en = 1'b1; man_val = 1'b1;
      repeat (4) @(negedge clk);
      b_cs = n_cs; b_rd = n_rd;
      pulse_start();
      wait_done("R5");
      repeat (15) @(negedge clk);
      chk("R5", "reads with line held active", n_rd - b_rd, N);
      chk("R5", "starts with line held active", n_cs - b_cs, PW);
    end

    // Timeout path and clearing of the flag
    begin
      int b_rd;
      man_val = 1'b0; adc_en = 1'b0;
      repeat (4) @(negedge clk);
      b_rd = n_rd;
      pulse_start();
      repeat (PW + TO + 4) @(negedge clk);
      chk("R9", "error flag after timeout", timeout_err, 1);
      chk("R9", "no reads on timeout", n_rd - b_rd, 0);
      repeat (10) @(negedge clk);
      chk("R9", "error flag sticky", timeout_err, 1);
      man_en = 1'b0; adc_en = 1'b1;
      pulse_start();
      chk("R9", "error cleared by start", timeout_err, 0);
      wait_done("R9");
    end

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule